// File: doc/BRIEF.md
# Exception Entry with Banked Registers

This block carries out the processor-side steps of taking an exception in one clock. A request arrives with a cause code, the program counter and the status word as they stand at that moment, and a control bit that picks the high or the low vector base. On acceptance the block chooses the target mode from the cause and moves the stack and link registers and the saved-status register between per-mode bank slots. It records the return address and the pre-exception status, and then produces a new status word (new mode, interrupts masked) and a new program counter at the cause's vector.

The block owns the three registers that a mode change swaps: the stack register (general register 29), the link register (general register 30) and the saved-status register. The register file writes them through a small write port while no exception is being taken. User and system mode share one bank slot. Privileged, trap and interrupt modes each have their own slot. A request whose cause or current mode is not recognised is refused and flagged, and it changes no state.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, every output is zero: stack, link, saved-status, new status, new PC, the taken pulse and the fault pulse.
- R2: Cause codes map to target modes (mode field = status bits [4:0]): code 0 (privileged call) gives 0x13, codes 1 (instruction abort) and 2 (data abort) give 0x17, and code 3 (interrupt) gives 0x12. The new status shows the target mode one cycle after the request.
- R3: The new status equals the incoming status with bits [4:0] replaced by the target mode and bit 7 (interrupt disable) set. All other bits are preserved.
- R4: On an accepted request, the saved-status register receives the full incoming status.
- R5: On an accepted request, the link register receives the incoming PC.
- R6: The new PC is the base plus the cause offset. The base is 0xFFFF0000 when the vector select bit is 1 and 0 when it is 0. The offsets are 0x08 for code 0, 0x0C for code 1, 0x10 for code 2 and 0x18 for code 3.
- R7: When the target mode differs from the current mode, the stack, link and saved-status values held before the request are stored in the current mode's slot, and the stack register is reloaded from the target mode's slot. The slots start at zero.
- R8: When the target mode equals the current mode, no slot is written and the stack register keeps its value.
- R9: The current modes 0x10 (user), 0x1F (system), 0x12, 0x13 and 0x17 are accepted, with user and system sharing one slot. Any other current mode value refuses the request.
- R10: A request with cause code 4 to 7 or an unaccepted current mode raises the fault output for one cycle. It leaves all registers and outputs other than the pulses unchanged, and it does not raise the taken output.
- R11: With no request in the cycle, a write with select 0, 1 or 2 loads the stack, link or saved-status register on the next cycle. Select 3 writes nothing. A write presented together with a request is dropped.
- R12: The taken output pulses in exactly the cycle after each accepted request, including requests on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception request, one cycle per request |
| exc_cause | input | 3 | Cause code (0 to 3 legal) |
| cur_pc | input | 32 | PC at the time of the request (return address) |
| cur_status | input | 32 | Status word at the time of the request |
| vec_hi_sel | input | 1 | Vector base select: 1 high, 0 low |
| gpr_we | input | 1 | Register write enable |
| gpr_sel | input | 2 | Write target: 0 stack, 1 link, 2 saved-status, 3 none |
| gpr_wdata | input | 32 | Write data |
| exc_taken | output | 1 | Pulse: request accepted |
| exc_fault | output | 1 | Pulse: request refused |
| new_status | output | 32 | Status word after the latest exception |
| new_pc | output | 32 | Vector address of the latest exception |
| sp_val | output | 32 | Current stack register |
| lr_val | output | 32 | Current link register |
| sstat_val | output | 32 | Current saved-status register |

## Verification
The assertions check on every cycle that an accepted request is followed by a taken pulse. In that pulse they check that the status carries an exception mode and the interrupt-disable bit, and that the link and saved-status registers hold the sampled PC and status. They also check that a same-mode entry leaves the stack register alone, that a refused request leaves every register stable, and that a slot write lands in the addressed slot. Only the bench's scenarios can show that a value stored when a mode is left comes back when that mode is entered again many cycles later. The same holds for the vector arithmetic for both bases and all four causes, and for a write being dropped when it meets a request. A behavioural model with its own bank arrays follows long random sequences and compares every output on every clock.

// File: rtl/exc_entry_pkg.sv
`timescale 1ns/1ps
package exc_entry_pkg;

   localparam int MODE_W = 5;

   typedef enum logic [MODE_W-1:0] {
      MODE_USER = 5'h10,
      MODE_INTR = 5'h12,
      MODE_PRIV = 5'h13,
      MODE_TRAP = 5'h17,
      MODE_SYS  = 5'h1F
   } mode_e;

   typedef enum logic [2:0] {
      CAUSE_PCALL = 3'd0,
      CAUSE_IABT  = 3'd1,
      CAUSE_DABT  = 3'd2,
      CAUSE_IRQ   = 3'd3
   } cause_e;

   typedef enum logic [1:0] {
      WSEL_SP   = 2'd0,
      WSEL_LR   = 2'd1,
      WSEL_SS   = 2'd2,
      WSEL_NONE = 2'd3
   } wsel_e;

   localparam int VOFF_W = 8;

endpackage

// File: rtl/exc_cause_decode.sv
`timescale 1ns/1ps
module exc_cause_decode
   import exc_entry_pkg::*;
(
   input  logic [2:0]        cause,
   output logic [MODE_W-1:0] tgt_mode,
   output logic [VOFF_W-1:0] vec_off,
   output logic              cause_ok
);

   always_comb begin
      tgt_mode = MODE_USER;
      vec_off  = '0;
      cause_ok = 1'b1;
      case (cause)
         CAUSE_PCALL: begin tgt_mode = MODE_PRIV; vec_off = 8'h08; end
         CAUSE_IABT:  begin tgt_mode = MODE_TRAP; vec_off = 8'h0C; end
         CAUSE_DABT:  begin tgt_mode = MODE_TRAP; vec_off = 8'h10; end
         CAUSE_IRQ:   begin tgt_mode = MODE_INTR; vec_off = 8'h18; end
         default:     cause_ok = 1'b0;
      endcase
   end

endmodule

// File: rtl/exc_mode_map.sv
`timescale 1ns/1ps
module exc_mode_map
   import exc_entry_pkg::*;
#(
   parameter int SLOT_W       = 2,
   parameter bit SYS_OWN_SLOT = 1'b0
) (
   input  logic [MODE_W-1:0] mode,
   output logic [SLOT_W-1:0] slot,
   output logic              known
);

   logic [SLOT_W-1:0] slot_base;

   always_comb begin
      slot_base = '0;
      known     = 1'b1;
      case (mode)
         MODE_USER: slot_base = SLOT_W'(0);
         MODE_SYS:  slot_base = SLOT_W'(0);
         MODE_PRIV: slot_base = SLOT_W'(1);
         MODE_TRAP: slot_base = SLOT_W'(2);
         MODE_INTR: slot_base = SLOT_W'(3);
         default:   known     = 1'b0;
      endcase
   end

   // Variant: system mode either shares the user slot or gets a fifth one.
   generate
      if (SYS_OWN_SLOT) begin : g_sys_own
         assign slot = (mode == MODE_SYS) ? SLOT_W'(4) : slot_base;
      end else begin : g_sys_shared
         assign slot = slot_base;
      end
   endgenerate

endmodule

// File: rtl/exc_bank_file.sv
`timescale 1ns/1ps
module exc_bank_file #(
   parameter int W         = 96,
   parameter int NUM_SLOTS = 4,
   parameter int SLOT_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              save_en,
   input  logic [SLOT_W-1:0] save_slot,
   input  logic [W-1:0]      save_data,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [W-1:0]      rd_data
);

   generate
      if (NUM_SLOTS > (1 << SLOT_W)) begin : g_bad_slots
         $error("exc_bank_file: slot index too narrow for NUM_SLOTS");
      end
   endgenerate

   logic [W-1:0] slot_q [NUM_SLOTS];

   generate
      for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n)
               slot_q[g] <= '0;
            else if (save_en && (save_slot == SLOT_W'(g)))
               slot_q[g] <= save_data;
         end
      end
   endgenerate

   assign rd_data = slot_q[rd_slot];

   // R7: a save lands in the addressed slot
   p_save_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
      save_en |=> (slot_q[$past(save_slot)] == $past(save_data)));

endmodule

// File: rtl/exc_entry_unit.sv
`timescale 1ns/1ps
module exc_entry_unit
   import exc_entry_pkg::*;
#(
   parameter int               XLEN         = 32,
   parameter int               NUM_SLOTS    = 4,
   parameter bit               SYS_OWN_SLOT = 1'b0,
   parameter int               IDIS_BIT     = 7,
   parameter logic [XLEN-1:0]  VEC_HI_BASE  = XLEN'(32'hFFFF_0000),
   parameter logic [XLEN-1:0]  VEC_LO_BASE  = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            exc_req,
   input  logic [2:0]      exc_cause,
   input  logic [XLEN-1:0] cur_pc,
   input  logic [XLEN-1:0] cur_status,
   input  logic            vec_hi_sel,
   input  logic            gpr_we,
   input  logic [1:0]      gpr_sel,
   input  logic [XLEN-1:0] gpr_wdata,
   output logic            exc_taken,
   output logic            exc_fault,
   output logic [XLEN-1:0] new_status,
   output logic [XLEN-1:0] new_pc,
   output logic [XLEN-1:0] sp_val,
   output logic [XLEN-1:0] lr_val,
   output logic [XLEN-1:0] sstat_val
);

   localparam int              SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
   localparam int              BANK_W    = 3 * XLEN;
   localparam int              MIN_SLOTS = SYS_OWN_SLOT ? 5 : 4;
   localparam logic [XLEN-1:0] MODE_MASK = XLEN'((1 << MODE_W) - 1);
   localparam logic [XLEN-1:0] IDIS_MASK = XLEN'(1) << IDIS_BIT;

   generate
      if (XLEN < 16) begin : g_bad_xlen
         $error("exc_entry_unit: XLEN below 16");
      end
      if (NUM_SLOTS < MIN_SLOTS) begin : g_bad_slots
         $error("exc_entry_unit: too few bank slots for the mode map");
      end
      if ((IDIS_BIT < MODE_W) || (IDIS_BIT >= XLEN)) begin : g_bad_idis
         $error("exc_entry_unit: interrupt-disable bit overlaps mode or exceeds word");
      end
   endgenerate

   typedef struct packed {
      logic [XLEN-1:0] sp;
      logic [XLEN-1:0] lr;
      logic [XLEN-1:0] ss;
   } bank_t;

   // decode
   logic [MODE_W-1:0] tgt_mode;
   logic [VOFF_W-1:0] vec_off;
   logic              cause_ok;
   logic [MODE_W-1:0] cur_mode;
   logic [SLOT_W-1:0] cur_slot, tgt_slot;
   logic              cur_known, tgt_known;

   assign cur_mode = cur_status[MODE_W-1:0];

   exc_cause_decode u_cause (
      .cause    (exc_cause),
      .tgt_mode (tgt_mode),
      .vec_off  (vec_off),
      .cause_ok (cause_ok)
   );

   exc_mode_map #(.SLOT_W(SLOT_W), .SYS_OWN_SLOT(SYS_OWN_SLOT)) u_cur_map (
      .mode  (cur_mode),
      .slot  (cur_slot),
      .known (cur_known)
   );

   exc_mode_map #(.SLOT_W(SLOT_W), .SYS_OWN_SLOT(SYS_OWN_SLOT)) u_tgt_map (
      .mode  (tgt_mode),
      .slot  (tgt_slot),
      .known (tgt_known)
   );

   logic accept, mode_change;
   assign accept      = exc_req && cause_ok && cur_known && tgt_known;
   assign mode_change = (cur_mode != tgt_mode);

   // banked state
   bank_t live_q, swapped, entered;
   logic [BANK_W-1:0] bank_rd;

   exc_bank_file #(.W(BANK_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .save_en   (accept && mode_change),
      .save_slot (cur_slot),
      .save_data (live_q),
      .rd_slot   (tgt_slot),
      .rd_data   (bank_rd)
   );

   // Step one swaps in the target slot; step two records the return state.
   always_comb begin
      swapped    = mode_change ? bank_t'(bank_rd) : live_q;
      entered    = swapped;
      entered.lr = cur_pc;
      entered.ss = cur_status;
   end

   logic [XLEN-1:0] vec_base, vec_addr, status_nx;
   assign vec_base  = vec_hi_sel ? VEC_HI_BASE : VEC_LO_BASE;
   assign vec_addr  = vec_base + XLEN'(vec_off);
   assign status_nx = (cur_status & ~MODE_MASK) | XLEN'(tgt_mode) | IDIS_MASK;

   logic [XLEN-1:0] status_q, pc_q;
   logic            taken_q, fault_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q   <= '0;
         status_q <= '0;
         pc_q     <= '0;
         taken_q  <= 1'b0;
         fault_q  <= 1'b0;
      end else begin
         taken_q <= accept;
         fault_q <= exc_req && !accept;
         if (accept) begin
            live_q   <= entered;
            status_q <= status_nx;
            pc_q     <= vec_addr;
         end else if (gpr_we && !exc_req) begin
            case (gpr_sel)
               WSEL_SP: live_q.sp <= gpr_wdata;
               WSEL_LR: live_q.lr <= gpr_wdata;
               WSEL_SS: live_q.ss <= gpr_wdata;
               default: ;
            endcase
         end
      end
   end

   assign exc_taken  = taken_q;
   assign exc_fault  = fault_q;
   assign new_status = status_q;
   assign new_pc     = pc_q;
   assign sp_val     = live_q.sp;
   assign lr_val     = live_q.lr;
   assign sstat_val  = live_q.ss;

   // R12: an accepted request is taken on the next cycle
   p_taken_next_r12: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> exc_taken);

   // R2: a taken pulse always shows an exception mode
   p_exc_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
      exc_taken |-> (new_status[MODE_W-1:0] == MODE_PRIV ||
                     new_status[MODE_W-1:0] == MODE_TRAP ||
                     new_status[MODE_W-1:0] == MODE_INTR));

   // R3: interrupts are masked after entry
   p_idis_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      exc_taken |-> new_status[IDIS_BIT]);

   // R4: saved status captures the incoming status
   p_sstat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (sstat_val == $past(cur_status)));

   // R5: link register captures the return PC
   p_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (lr_val == $past(cur_pc)));

   // R8: same-mode entry keeps the stack register
   p_same_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !mode_change) |=> $stable(sp_val));

   // R10: a refused request leaves all state unchanged
   p_fault_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      exc_fault |-> (!exc_taken && $stable(sp_val) && $stable(lr_val) &&
                     $stable(sstat_val) && $stable(new_status) && $stable(new_pc)));

endmodule

// File: tb/exc_entry_unit_tb.sv
`timescale 1ns/1ps
module exc_entry_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_req = 1'b0;
   logic [2:0]  exc_cause = '0;
   logic [31:0] cur_pc = '0;
   logic [31:0] cur_status = '0;
   logic        vec_hi_sel = 1'b0;
   logic        gpr_we = 1'b0;
   logic [1:0]  gpr_sel = '0;
   logic [31:0] gpr_wdata = '0;
   logic        exc_taken, exc_fault;
   logic [31:0] new_status, new_pc, sp_val, lr_val, sstat_val;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   exc_entry_unit u_dut (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause),
      .cur_pc(cur_pc), .cur_status(cur_status), .vec_hi_sel(vec_hi_sel),
      .gpr_we(gpr_we), .gpr_sel(gpr_sel), .gpr_wdata(gpr_wdata),
      .exc_taken(exc_taken), .exc_fault(exc_fault), .new_status(new_status),
      .new_pc(new_pc), .sp_val(sp_val), .lr_val(lr_val), .sstat_val(sstat_val)
   );

   // ---------------- behavioural reference model ----------------
   int unsigned m_sp, m_lr, m_ss, m_status, m_pc;
   bit          m_taken, m_fault;
   int unsigned b_sp [5];
   int unsigned b_lr [5];
   int unsigned b_ss [5];
   int          nm, cs, ts;

   function automatic int mode_for(input int c);
      if (c == 0) return 'h13;
      if (c == 1 || c == 2) return 'h17;
      if (c == 3) return 'h12;
      return -1;
   endfunction

   function automatic int offset_for(input int c);
      int offs [4] = '{'h08, 'h0C, 'h10, 'h18};
      return offs[c];
   endfunction

   function automatic int slot_for(input int m);
      if (m == 'h10 || m == 'h1F) return 0;
      if (m == 'h13) return 1;
      if (m == 'h17) return 2;
      if (m == 'h12) return 3;
      return -1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sp = 0; m_lr = 0; m_ss = 0; m_status = 0; m_pc = 0;
         m_taken = 0; m_fault = 0;
         foreach (b_sp[i]) begin b_sp[i] = 0; b_lr[i] = 0; b_ss[i] = 0; end
      end else begin
         m_taken = 0;
         m_fault = 0;
         if (exc_req) begin
            nm = mode_for(int'(exc_cause));
            cs = slot_for(int'(cur_status[4:0]));
            if (nm < 0 || cs < 0) begin
               m_fault = 1;
            end else begin
               m_taken = 1;
               ts = slot_for(nm);
               if (int'(cur_status[4:0]) != nm) begin
                  b_sp[cs] = m_sp; b_lr[cs] = m_lr; b_ss[cs] = m_ss;
                  m_sp = b_sp[ts];
               end
               m_lr = cur_pc;
               m_ss = cur_status;
               m_status = (cur_status & ~32'h1F) | nm | 32'h80;
               m_pc = (vec_hi_sel ? 32'hFFFF_0000 : 32'h0) + offset_for(int'(exc_cause));
            end
         end else if (gpr_we) begin
            if (gpr_sel == 0) m_sp = gpr_wdata;
            else if (gpr_sel == 1) m_lr = gpr_wdata;
            else if (gpr_sel == 2) m_ss = gpr_wdata;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R12 taken",      {31'b0, exc_taken}, {31'b0, m_taken});
         chk("R10 fault",      {31'b0, exc_fault}, {31'b0, m_fault});
         chk("R3 status",      new_status, m_status);
         chk("R6 pc",          new_pc, m_pc);
         chk("R7 stack",       sp_val, m_sp);
         chk("R5 link",        lr_val, m_lr);
         chk("R4 saved-stat",  sstat_val, m_ss);
      end
   end

   // ---------------- stimulus ----------------
   task automatic idle();
      exc_req = 0; gpr_we = 0;
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      exc_req = 0; gpr_we = 1; gpr_sel = sel; gpr_wdata = d;
      @(negedge clk);
      gpr_we = 0;
   endtask

   task automatic req(input logic [2:0] c, input logic [31:0] pc,
                      input logic [31:0] st, input logic hi);
      exc_req = 1; exc_cause = c; cur_pc = pc; cur_status = st; vec_hi_sel = hi;
      @(negedge clk);
      exc_req = 0;
   endtask

   function automatic logic [31:0] pick_status();
      logic [4:0] modes [6] = '{5'h10, 5'h12, 5'h13, 5'h17, 5'h1F, 5'h05};
      logic [31:0] s;
      s = $urandom;
      s[4:0] = modes[$urandom % 6];
      return s;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 sp",     sp_val, 0);
      chk("R1 lr",     lr_val, 0);
      chk("R1 sstat",  sstat_val, 0);
      chk("R1 status", new_status, 0);
      chk("R1 pc",     new_pc, 0);
      chk("R1 pulses", {30'b0, exc_taken, exc_fault}, 0);
      rst_n = 1;
      @(negedge clk);

      // R11 writes
      wr(2'd0, 32'hAAAA_0001);
      chk("R11 sp write", sp_val, 32'hAAAA_0001);
      wr(2'd1, 32'h0000_1234);
      wr(2'd2, 32'h0000_0055);
      chk("R11 ss write", sstat_val, 32'h0000_0055);
      wr(2'd3, 32'hDEAD_BEEF);
      chk("R11 sel3 none", {sp_val ^ lr_val ^ sstat_val}, 32'hAAAA_0001 ^ 32'h1234 ^ 32'h55);

      // R2 R3 R4 R5 R6 R7: user -> interrupt, low base
      req(3'd3, 32'h0000_0100, 32'h0000_0010, 1'b0);
      chk("R12 taken pulse", {31'b0, exc_taken}, 1);
      chk("R2 irq mode/R3", new_status, 32'h0000_0092);
      chk("R6 irq low", new_pc, 32'h0000_0018);
      chk("R5 lr", lr_val, 32'h0000_0100);
      chk("R4 ss", sstat_val, 32'h0000_0010);
      chk("R7 sp fresh slot", sp_val, 0);

      wr(2'd0, 32'hBBBB_0002);
      // R3 bits preserved, R6 high base: interrupt -> privileged
      req(3'd0, 32'h0000_0200, 32'hF000_0012, 1'b1);
      chk("R3 preserve", new_status, 32'hF000_0093);
      chk("R6 pcall high", new_pc, 32'hFFFF_0008);
      chk("R7 sp priv slot", sp_val, 0);

      // privileged -> trap via instruction abort (back-to-back R12)
      req(3'd1, 32'h0000_0300, 32'h0000_0013, 1'b0);
      chk("R6 iabt", new_pc, 32'h0000_000C);
      chk("R2 trap mode", {27'b0, new_status[4:0]}, 32'h17);
      req(3'd3, 32'h0000_0400, 32'h0000_0017, 1'b1);
      chk("R12 back-to-back", {31'b0, exc_taken}, 1);
      chk("R7 restore intr sp", sp_val, 32'hBBBB_0002);
      chk("R6 irq high", new_pc, 32'hFFFF_0018);

      // R8 same mode: trap -> trap via data abort
      wr(2'd0, 32'hDDDD_0004);
      req(3'd2, 32'h0000_0500, 32'h0000_0017, 1'b0);
      chk("R8 sp kept", sp_val, 32'hDDDD_0004);
      chk("R6 dabt", new_pc, 32'h0000_0010);

      // R9 system mode accepted
      req(3'd0, 32'h0000_0600, 32'h0000_001F, 1'b0);
      chk("R9 system ok", {31'b0, exc_taken}, 1);

      // R10 bad cause and bad mode
      req(3'd5, 32'h0000_0700, 32'h0000_0010, 1'b0);
      chk("R10 bad cause", {30'b0, exc_taken, exc_fault}, 1);
      chk("R10 lr kept", lr_val, 32'h0000_0600);
      req(3'd0, 32'h0000_0800, 32'h0000_0005, 1'b0);
      chk("R9 bad mode fault", {30'b0, exc_taken, exc_fault}, 1);

      // R11 write dropped with a request
      exc_req = 1; exc_cause = 3'd3; cur_pc = 32'h900; cur_status = 32'h13; vec_hi_sel = 0;
      gpr_we = 1; gpr_sel = 2'd1; gpr_wdata = 32'h7777_7777;
      @(negedge clk);
      exc_req = 0; gpr_we = 0;
      chk("R11 write dropped", lr_val, 32'h0000_0900);

      // random sequences against the model
      for (int n = 0; n < 2000; n++) begin
         exc_req    = ($urandom % 10) < 6;
         exc_cause  = (($urandom % 8) == 0) ? 3'($urandom % 8) : 3'($urandom % 4);
         cur_pc     = $urandom;
         cur_status = pick_status();
         vec_hi_sel = $urandom % 2;
         gpr_we     = $urandom % 2;
         gpr_sel    = 2'($urandom % 4);
         gpr_wdata  = $urandom;
         @(negedge clk);
      end
      idle();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog R12 actual=%h expected=%h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule